// File: doc/BRIEF.md
# Write Strobe Qualifier

This block turns three active-low control pins (chip enable, output enable, write enable) into clean, single-cycle load requests for a memory write engine. The pins are treated as asynchronous. Each one passes through a synchroniser clocked by a fast sampling clock. The block then looks for a window in which chip enable and write enable are both low while output enable is high. That overlap frames one write cycle. The address is taken at the start of the overlap, which is the later of the two falling strobes. The data is taken at its end, which is the earlier of the two rising strobes.

A write is dropped in three cases. The first is an overlap shorter than a programmable number of sample clocks, so that glitches are rejected. The second is output enable going low during the overlap. The third is the supply being reported bad, or having been good for less than a programmable power-on delay. A qualified cycle produces exactly one load pulse, together with the captured address and data.

The address and data buses are delayed by the same number of stages as the synchroniser. This keeps their sampling aligned with the filtered strobe edges.

Top module: `wr_strobe_qual`

## Requirements
- R1: A write is accepted when ceN and weN are both low and oeN is high. Either strobe may be the last to fall, so writes controlled by chip enable and writes controlled by write enable both work.
- R2: loadAddr carries the addrIn value present when the later of ceN/weN falls. Address changes before that point, while only one strobe is low, are not used.
- R3: loadData carries the dataIn value present when the earlier of ceN/weN rises. Data changes earlier in the overlap or after that rise are not used.
- R4: If oeN is low when the strobes start to overlap, no write happens. If oeN goes low at any point during the overlap, no write happens either. Raising oeN while both strobes stay low does not start a write.
- R5: An overlap lasting fewer than FILT_CYC sample clocks produces no load. An overlap of exactly FILT_CYC clocks produces one load.
- R6: No load occurs while supplyGood is low. No load occurs until PON_CYC clocks after supplyGood has been seen high. A drop of supplyGood restarts this lockout.
- R7: Suppose the first rising strobe is sampled high at clock edge e. Then loadValid is high for the cycle that follows edge e+3, and low before that cycle.
- R8: Each qualified cycle gives exactly one loadValid pulse, one clock wide.
- R9: After reset loadValid is low and the power-on lockout is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyGood | input | 1 | High when the supply is within range |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addrIn | input | ADDR_W | Address bus |
| dataIn | input | DATA_W | Data bus |
| loadValid | output | 1 | One-clock load strobe to the write engine |
| loadAddr | output | ADDR_W | Captured address |
| loadData | output | DATA_W | Captured data |

## Verification
The load pulse trails the first clock edge that samples a rising strobe by three edges: two synchroniser stages, the state register and the output flop. The timing task counts posedges from the rise and samples loadValid at the negedge just before, at and after the expected cycle. Every other task drives at negedges and waits well past that latency before reading a pulse counter kept by a negedge monitor. A missing load, an extra load or a two-cycle load all show up as a wrong count. The captured address and data are compared with the values driven at the later fall and at the first rise.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  typedef struct packed {
    logic capAddr;
    logic capData;
    logic fire;
  } wsqStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIRE  = 2'd3
  } wsqState_e;
endpackage

// File: rtl/wsq_sync.sv
module wsq_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] rawIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= RST_VAL;
          else       stage[i] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= RST_VAL;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/wsq_ctrl.sv
module wsq_ctrl
  import wsq_pkg::*;
#(
  parameter int FILT_CYC = 2,
  parameter int PON_CYC  = 625000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ceS,
  input  logic     weS,
  input  logic     oeS,
  input  logic     sgS,
  output wsqStrb_t strb
);
  localparam int FCW = $clog2(FILT_CYC + 1);
  localparam int LCW = $clog2(PON_CYC + 1);

  wsqState_e      state, stateNext;
  logic [FCW-1:0] ovlCnt;
  logic [LCW-1:0] lockCnt;
  logic           unlocked;
  logic           both;

  assign both     = !ceS && !weS;
  assign unlocked = (lockCnt == LCW'(PON_CYC));

  // power-on lockout: counts clocks of good supply, clears on any drop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lockCnt <= '0;
    else if (!sgS)      lockCnt <= '0;
    else if (!unlocked) lockCnt <= lockCnt + 1'b1;
  end

  always_comb begin
    stateNext    = state;
    strb         = '0;
    unique case (state)
      ST_IDLE: begin
        if (both) begin
          if (oeS && unlocked) begin
            stateNext    = ST_COUNT;
            strb.capAddr = 1'b1;
          end else begin
            stateNext = ST_WAIT;
          end
        end
      end
      ST_COUNT: begin
        if (!both) begin
          if (ovlCnt >= FCW'(FILT_CYC) && unlocked) begin
            stateNext    = ST_FIRE;
            strb.capData = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end else if (!oeS || !unlocked) begin
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!both) stateNext = ST_IDLE;
      end
      ST_FIRE: begin
        strb.fire = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ovlCnt <= '0;
    end else begin
      state <= stateNext;
      if (strb.capAddr)
        ovlCnt <= FCW'(1);
      else if (state == ST_COUNT && both && ovlCnt < FCW'(FILT_CYC))
        ovlCnt <= ovlCnt + 1'b1;
    end
  end

  AST_OE_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNT && both && !oeS) |=> !strb.capData); // R4
  AST_LOCK_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sgS) |=> !unlocked); // R6
  AST_FIRE_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIRE) |-> $past(unlocked)); // R6
endmodule

// File: rtl/wsq_dpath.sv
module wsq_dpath
  import wsq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wsqStrb_t          strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              loadValid,
  output logic [ADDR_W-1:0] loadAddr,
  output logic [DATA_W-1:0] loadData
);
  logic [ADDR_W-1:0] addrPipe [STAGES];
  logic [DATA_W-1:0] dataPipe [STAGES];
  logic [ADDR_W-1:0] addrHold;
  logic              validQ;

  // delay the buses by the synchroniser depth so captures line up with edges
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_pipe
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          addrPipe[i] <= addrIn;
          dataPipe[i] <= dataIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          addrPipe[i] <= addrPipe[i-1];
          dataPipe[i] <= dataPipe[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
      loadAddr <= '0;
      loadData <= '0;
      validQ   <= 1'b0;
    end else begin
      if (strb.capAddr) addrHold <= addrPipe[STAGES-1];
      if (strb.capData) begin
        loadAddr <= addrHold;
        loadData <= dataPipe[STAGES-1];
      end
      validQ <= strb.fire;
    end
  end

  assign loadValid = validQ;

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> !loadValid); // R8
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(strb.capData, 2)); // R7
endmodule

// File: rtl/wr_strobe_qual.sv
module wr_strobe_qual
  import wsq_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 2,
  parameter int PON_CYC     = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              loadValid,
  output logic [ADDR_W-1:0] loadAddr,
  output logic [DATA_W-1:0] loadData
);
  localparam int NCTL = 4;

  logic [NCTL-1:0] ctlSync;
  wsqStrb_t        strb;

  wsq_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
    .clk(clk), .rstN(rstN),
    .rawIn({supplyGood, oeN, weN, ceN}),
    .syncOut(ctlSync)
  );

  wsq_ctrl #(.FILT_CYC(FILT_CYC), .PON_CYC(PON_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ceS(ctlSync[0]), .weS(ctlSync[1]), .oeS(ctlSync[2]), .sgS(ctlSync[3]),
    .strb(strb)
  );

  wsq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .addrIn(addrIn), .dataIn(dataIn),
    .loadValid(loadValid), .loadAddr(loadAddr), .loadData(loadData)
  );
endmodule

// File: tb/sim_wr_strobe_qual.sv
`timescale 1ns/1ps
module sim_wr_strobe_qual;
  localparam int AW = 17;
  localparam int DW = 32;
  localparam int FILT = 3;
  localparam int PON = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          supplyGood = 1'b0;
  logic          ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic          loadValid;
  logic [AW-1:0] loadAddr;
  logic [DW-1:0] loadData;

  int vectors = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;
  logic [AW-1:0] seenAddr = '0;
  logic [DW-1:0] seenData = '0;

  always #4 clk = ~clk;

  wr_strobe_qual #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2),
                   .FILT_CYC(FILT), .PON_CYC(PON)) u0 (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood),
    .ceN(ceN), .oeN(oeN), .weN(weN), .addrIn(addrIn), .dataIn(dataIn),
    .loadValid(loadValid), .loadAddr(loadAddr), .loadData(loadData)
  );

  always @(negedge clk) begin
    if (rstN && loadValid) begin
      pulses++;
      seenAddr = loadAddr;
      seenData = loadData;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobeWrite(input bit ceLeads, input int lowCyc,
                             input logic [AW-1:0] a, input logic [DW-1:0] d);
    addrIn = a; dataIn = d;
    if (ceLeads) ceN = 1'b0; else weN = 1'b0;
    cyc(2);
    if (ceLeads) weN = 1'b0; else ceN = 1'b0;
    cyc(lowCyc);
    if (ceLeads) weN = 1'b1; else ceN = 1'b1;
    cyc(2);
    ceN = 1'b1; weN = 1'b1;
    cyc(8);
  endtask

  task automatic tReset();
    check("R9 loadValid after reset", 64'(loadValid), 64'd0);
    check("R9 no pulses after reset", 64'(pulses), 64'd0);
  endtask

  task automatic tLockout();
    int p0 = pulses;
    strobeWrite(1'b1, 6, 17'h00011, 32'h1111_0000);
    check("R6 supply low blocks", 64'(pulses - p0), 64'd0);
    supplyGood = 1'b1;
    cyc(2);
    strobeWrite(1'b1, 6, 17'h00022, 32'h2222_0000);
    check("R6 power-on delay blocks", 64'(pulses - p0), 64'd0);
    cyc(PON + 6);
    strobeWrite(1'b1, 6, 17'h00033, 32'h3333_0000);
    check("R6 write after delay", 64'(pulses - p0), 64'd1);
  endtask

  task automatic tWeCtrl();
    int p0 = pulses;
    strobeWrite(1'b1, 5, 17'h1ABCD, 32'hDEAD_BEEF);
    check("R8 one pulse write-enable controlled", 64'(pulses - p0), 64'd1);
    check("R1 address write-enable controlled", 64'(seenAddr), 64'h1ABCD);
    check("R1 data write-enable controlled", 64'(seenData), 64'hDEAD_BEEF);
  endtask

  task automatic tCeCtrl();
    int p0 = pulses;
    strobeWrite(1'b0, 5, 17'h05555, 32'hCAFE_F00D);
    check("R1 one pulse chip-enable controlled", 64'(pulses - p0), 64'd1);
    check("R1 address chip-enable controlled", 64'(seenAddr), 64'h05555);
    check("R1 data chip-enable controlled", 64'(seenData), 64'hCAFE_F00D);
  endtask

  task automatic tAddrLate();
    int p0 = pulses;
    addrIn = 17'h0AAAA; dataIn = 32'h0000_1234;
    ceN = 1'b0;
    cyc(3);
    addrIn = 17'h12AAA;
    cyc(1);
    weN = 1'b0;
    cyc(2);
    addrIn = 17'h00F0F;
    cyc(4);
    weN = 1'b1;
    cyc(2);
    ceN = 1'b1;
    cyc(8);
    check("R2 one pulse", 64'(pulses - p0), 64'd1);
    check("R2 address at later fall", 64'(seenAddr), 64'h12AAA);
  endtask

  task automatic tDataFirst();
    int p0 = pulses;
    addrIn = 17'h00777; dataIn = 32'h0000_00D0;
    weN = 1'b0;
    cyc(2);
    ceN = 1'b0;
    cyc(2);
    dataIn = 32'h0000_00D1;
    cyc(4);
    ceN = 1'b1;
    cyc(1);
    dataIn = 32'h0000_00D2;
    cyc(2);
    weN = 1'b1;
    cyc(8);
    check("R3 one pulse", 64'(pulses - p0), 64'd1);
    check("R3 data at first rise", 64'(seenData), 64'h0000_00D1);
  endtask

  task automatic tFilter();
    int p0 = pulses;
    strobeWrite(1'b1, FILT - 1, 17'h00100, 32'h0000_0F01);
    check("R5 short overlap rejected", 64'(pulses - p0), 64'd0);
    strobeWrite(1'b0, 1, 17'h00101, 32'h0000_0F02);
    check("R5 glitch rejected", 64'(pulses - p0), 64'd0);
    strobeWrite(1'b1, FILT, 17'h00102, 32'h0000_0F03);
    check("R5 overlap at filter width accepted", 64'(pulses - p0), 64'd1);
    check("R5 data at filter width", 64'(seenData), 64'h0000_0F03);
  endtask

  task automatic tOeInhibit();
    int p0 = pulses;
    addrIn = 17'h00200; dataIn = 32'h0000_0E01;
    ceN = 1'b0;
    cyc(2);
    weN = 1'b0;
    cyc(4);
    oeN = 1'b0;
    cyc(2);
    oeN = 1'b1;
    cyc(4);
    weN = 1'b1; ceN = 1'b1;
    cyc(8);
    check("R4 oe low mid overlap", 64'(pulses - p0), 64'd0);
    oeN = 1'b0;
    cyc(1);
    ceN = 1'b0; weN = 1'b0;
    cyc(4);
    oeN = 1'b1;
    cyc(6);
    weN = 1'b1; ceN = 1'b1;
    cyc(8);
    check("R4 oe low at overlap start then raised", 64'(pulses - p0), 64'd0);
  endtask

  task automatic tTiming();
    addrIn = 17'h00300; dataIn = 32'h0000_7777;
    ceN = 1'b0;
    cyc(2);
    weN = 1'b0;
    cyc(5);
    weN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 low before due cycle", 64'(loadValid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R7 high in due cycle", 64'(loadValid), 64'd1);
    @(posedge clk);
    @(negedge clk);
    check("R8 one clock wide", 64'(loadValid), 64'd0);
    ceN = 1'b1;
    cyc(8);
  endtask

  task automatic tSupplyDrop();
    int p0 = pulses;
    supplyGood = 1'b0;
    cyc(4);
    supplyGood = 1'b1;
    cyc(2);
    strobeWrite(1'b0, 6, 17'h00400, 32'h0000_4444);
    check("R6 lockout restarts after drop", 64'(pulses - p0), 64'd0);
    cyc(PON + 6);
    strobeWrite(1'b0, 6, 17'h00401, 32'h0000_4445);
    check("R6 write after restart delay", 64'(pulses - p0), 64'd1);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    tReset();
    tLockout();
    tWeCtrl();
    tCeCtrl();
    tAddrLate();
    tDataFirst();
    tFilter();
    tOeInhibit();
    tTiming();
    tSupplyDrop();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule